// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block is the modem-control slice of a 16550-style UART. It holds a seven-field control register on a 32-bit register bus. From that register it drives the four active-low modem outputs (terminal ready, request to send, and two general-purpose outputs). When automatic flow control is on and the FIFOs are enabled, it holds request-to-send inactive while the receive FIFO sits above its trigger level.

In diagnostic loopback the block reroutes both the modem and serial paths. The modem outputs go inactive, and the register values are presented to the status logic in place of the external modem inputs. Serial data is turned around inside the block. The plain serial line does this with its pin held high. The infrared line does it with its pin held low and the looped data inverted. A small change detector watches the four status lines the receiver side sees, so change events keep working in loopback.

The transmitter, receiver, FIFOs, baud generation and infrared pulse shaping are outside this block and reach it only through ports.

Top module: `uart_modem_ctl`

## Requirements
- R1: During and after reset every control field is 0: the register reads 0, all four modem outputs are high, the plain serial pin follows the transmitter and the infrared pin follows the infrared transmitter.
- R2: A write with `bus_wr`=1 and `bus_addr`=`CTRL_OFFSET` stores `bus_wdata[6:0]` at the next rising edge. Field positions are: bit 0 dtr, 1 rts, 2 out1, 3 out2, 4 loop, 5 afce, 6 sire. A read at that address returns the stored fields, with bits 31:7 read as 0.
- R3: The afce field can be written only when `AFC_EN`=1, and the sire field only when `IR_EN`=1. Otherwise the field stays 0 whatever is written.
- R4: With loop=0, `dtr_n`, `out1_n` and `out2_n` each equal the inverse of their field.
- R5: With loop=0, `rts_n` is the inverse of rts, except when afce=1, `fifo_en`=1 and `rx_above_trig`=1. In that case `rts_n` is 1.
- R6: With loop=1, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all 1.
- R7: With loop=1, the status outputs are `cts_st_n`=~rts, `dsr_st_n`=~dtr, `ri_st_n`=~out1 and `dcd_st_n`=~out2, and the four external modem pins have no effect on them.
- R8: With loop=0, each status output equals its external modem pin.
- R9: With loop=1 and sire=0, `sout`=1 and `rx_ser`=`tx_ser`. Otherwise `sout`=`tx_ser` and `rx_ser`=`sin`.
- R10: With loop=1 and sire=1, `ir_tx_pin`=0 and `rx_ir`=~`tx_ir`. Otherwise `ir_tx_pin`=`tx_ir` and `rx_ir`=`ir_rx_pin`.
- R11: A change of `cts_st_n`, `dsr_st_n` or `dcd_st_n` sampled at a rising edge raises the matching event output for exactly the following cycle. `teri_evt` does the same only for a 0-to-1 transition of `ri_st_n`. This includes changes caused by register writes in loopback.
- R12: A write to any other address leaves the register unchanged, and a read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| fifo_en | input | 1 | FIFOs enabled |
| rx_above_trig | input | 1 | Receive FIFO above trigger level |
| cts_pin_n | input | 1 | External clear-to-send |
| dsr_pin_n | input | 1 | External data-set-ready |
| ri_pin_n | input | 1 | External ring indicator |
| dcd_pin_n | input | 1 | External carrier detect |
| dtr_n | output | 1 | Terminal-ready pin |
| rts_n | output | 1 | Request-to-send pin |
| out1_n | output | 1 | General output 1 pin |
| out2_n | output | 1 | General output 2 pin |
| cts_st_n | output | 1 | Clear-to-send seen by status logic |
| dsr_st_n | output | 1 | Data-set-ready seen by status logic |
| ri_st_n | output | 1 | Ring indicator seen by status logic |
| dcd_st_n | output | 1 | Carrier detect seen by status logic |
| dcts_evt | output | 1 | Clear-to-send change event |
| ddsr_evt | output | 1 | Data-set-ready change event |
| teri_evt | output | 1 | Ring indicator trailing-edge event |
| ddcd_evt | output | 1 | Carrier detect change event |
| tx_ser | input | 1 | Transmitter serial output |
| sin | input | 1 | Serial input pin |
| sout | output | 1 | Serial output pin |
| rx_ser | output | 1 | Serial input to receiver |
| tx_ir | input | 1 | Transmitter infrared output |
| ir_rx_pin | input | 1 | Infrared input pin |
| ir_tx_pin | output | 1 | Infrared output pin |
| rx_ir | output | 1 | Infrared input to receiver |

## Verification
The control register is the only stored state apart from the change detector. A wrong field value therefore appears on the pins and the register read at once, in the first cycle after the write edge, through the pin mux or the serial route. The bench sweeps every combination of loop, afce, FIFO enable, sire and FIFO fill against a model. A stale or corrupted previous-status sample in the change detector shows up as a missing, extra or doubled event pulse one cycle after the status change. That is checked with both pin-driven and write-driven changes, including the one-directional ring event.

// File: rtl/uart_mc_pkg.sv
// Package: shared field layout of the modem control register.
// Assumes the field order below; downstream decode depends on it.
package uart_mc_pkg;
    localparam int unsigned CTRL_W = 7;

    // Control fields, most significant first so bit positions match the bus.
    typedef struct packed {
        logic sire;   // bit 6: infrared mode
        logic afce;   // bit 5: automatic flow control
        logic loop;   // bit 4: diagnostic loopback
        logic out2;   // bit 3
        logic out1;   // bit 2
        logic rts;    // bit 1
        logic dtr;    // bit 0
    } mc_ctrl_t;

    // Index of each status line inside the 4-bit status vector.
    localparam int unsigned ST_CTS = 0;
    localparam int unsigned ST_DSR = 1;
    localparam int unsigned ST_RI  = 2;
    localparam int unsigned ST_DCD = 3;
    localparam int unsigned ST_W   = 4;
endpackage

// File: rtl/mc_ctrl_reg.sv
// Module: control register with bus write and combinational read.
// Assumes a single-cycle write strobe qualified by the address; optional
// fields are built as flops only when their feature parameter is set.
module mc_ctrl_reg
    import uart_mc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h10,
    parameter bit          IR_EN       = 1'b1,
    parameter bit          AFC_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CTRL_W-1:0] wr_fields,
    output logic [DATA_W-1:0] bus_rdata,
    output mc_ctrl_t          ctrl
);
    localparam int unsigned PAD_W = DATA_W - CTRL_W;

    logic     hit;
    logic     wr_hit;
    mc_ctrl_t wr_val;

    // Decode this register's address.
    assign hit    = (bus_addr == CTRL_OFFSET);
    assign wr_hit = hit && bus_wr;
    assign wr_val = mc_ctrl_t'(wr_fields);

    // Always-present fields: dtr, rts, out1, out2, loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.dtr  <= 1'b0;
            ctrl.rts  <= 1'b0;
            ctrl.out1 <= 1'b0;
            ctrl.out2 <= 1'b0;
            ctrl.loop <= 1'b0;
        end else if (wr_hit) begin
            ctrl.dtr  <= wr_val.dtr;
            ctrl.rts  <= wr_val.rts;
            ctrl.out1 <= wr_val.out1;
            ctrl.out2 <= wr_val.out2;
            ctrl.loop <= wr_val.loop;
        end
    end

    // Flow-control field: a flop when built, a constant zero otherwise.
    generate
        if (AFC_EN) begin : g_afce
            always_ff @(posedge clk) begin
                if (!rst_n)      ctrl.afce <= 1'b0;
                else if (wr_hit) ctrl.afce <= wr_val.afce;
            end
        end else begin : g_no_afce
            assign ctrl.afce = 1'b0;
        end
    endgenerate

    // Infrared field: a flop when built, a constant zero otherwise.
    generate
        if (IR_EN) begin : g_sire
            always_ff @(posedge clk) begin
                if (!rst_n)      ctrl.sire <= 1'b0;
                else if (wr_hit) ctrl.sire <= wr_val.sire;
            end
        end else begin : g_no_sire
            assign ctrl.sire = 1'b0;
        end
    endgenerate

    // Read mux: stored fields at this address, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit) bus_rdata = {{PAD_W{1'b0}}, ctrl};
    end
endmodule

// File: rtl/mc_modem_mux.sv
// Module: modem output drive, flow-control gating and status source select.
// Assumes external modem pins are already synchronised to clk.
module mc_modem_mux
    import uart_mc_pkg::*;
(
    input  mc_ctrl_t        ctrl,
    input  logic            fifo_en,
    input  logic            rx_above_trig,
    input  logic [ST_W-1:0] pins_n,
    output logic            dtr_n,
    output logic            rts_n,
    output logic            out1_n,
    output logic            out2_n,
    output logic [ST_W-1:0] status_n
);
    logic rts_hold;
    logic rts_eff;
    logic [ST_W-1:0] looped_n;

    // Flow-control hold: FIFO above trigger with the feature active.
    assign rts_hold = ctrl.afce && fifo_en && rx_above_trig;
    assign rts_eff  = ctrl.rts && !rts_hold;

    // Output pins: inverse of fields, forced inactive in loopback.
    always_comb begin
        dtr_n  = ctrl.loop | ~ctrl.dtr;
        rts_n  = ctrl.loop | ~rts_eff;
        out1_n = ctrl.loop | ~ctrl.out1;
        out2_n = ctrl.loop | ~ctrl.out2;
    end

    // Loopback mapping, kept active-low like the pins.
    always_comb begin
        looped_n         = '1;
        looped_n[ST_CTS] = ~ctrl.rts;
        looped_n[ST_DSR] = ~ctrl.dtr;
        looped_n[ST_RI]  = ~ctrl.out1;
        looped_n[ST_DCD] = ~ctrl.out2;
    end

    // Status source select.
    assign status_n = ctrl.loop ? looped_n : pins_n;
endmodule

// File: rtl/mc_serial_route.sv
// Module: serial and infrared path selection for diagnostic loopback.
// Assumes sire is already forced to zero when infrared is not built.
module mc_serial_route (
    input  logic loop,
    input  logic sire,
    input  logic tx_ser,
    input  logic sin,
    input  logic tx_ir,
    input  logic ir_rx_pin,
    output logic sout,
    output logic rx_ser,
    output logic ir_tx_pin,
    output logic rx_ir
);
    logic lb_plain;
    logic lb_ir;

    // Which loopback flavour is active.
    assign lb_plain = loop && !sire;
    assign lb_ir    = loop && sire;

    // Plain serial line: pin idles high, transmitter feeds receiver.
    always_comb begin
        sout   = lb_plain ? 1'b1   : tx_ser;
        rx_ser = lb_plain ? tx_ser : sin;
    end

    // Infrared line: pin idles low, inverted transmitter feeds receiver.
    always_comb begin
        ir_tx_pin = lb_ir ? 1'b0   : tx_ir;
        rx_ir     = lb_ir ? ~tx_ir : ir_rx_pin;
    end
endmodule

// File: rtl/mc_delta_det.sv
// Module: change detector on the active-low status lines.
// Assumes previous values reset to inactive (1); the ring line reports
// only its 0-to-1 transition, the others report any change.
module mc_delta_det
    import uart_mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] status_n,
    output logic [ST_W-1:0] evt
);
    logic [ST_W-1:0] prev_q;

    // Previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= status_n;
    end

    // Per-line event flop; the ring line uses trailing-edge detection.
    generate
        for (genvar i = 0; i < ST_W; i++) begin : g_line
            if (i == ST_RI) begin : g_trail
                always_ff @(posedge clk) begin
                    if (!rst_n) evt[i] <= 1'b0;
                    else        evt[i] <= status_n[i] && !prev_q[i];
                end
            end else begin : g_any
                always_ff @(posedge clk) begin
                    if (!rst_n) evt[i] <= 1'b0;
                    else        evt[i] <= status_n[i] ^ prev_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/uart_modem_ctl.sv
// Module: top of the modem-control slice of a 16550-style UART.
// Assumes a synchronous active-low reset and pre-synchronised modem pins.
module uart_modem_ctl
    import uart_mc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h10,
    parameter bit          IR_EN       = 1'b1,
    parameter bit          AFC_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fifo_en,
    input  logic              rx_above_trig,
    input  logic              cts_pin_n,
    input  logic              dsr_pin_n,
    input  logic              ri_pin_n,
    input  logic              dcd_pin_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              cts_st_n,
    output logic              dsr_st_n,
    output logic              ri_st_n,
    output logic              dcd_st_n,
    output logic              dcts_evt,
    output logic              ddsr_evt,
    output logic              teri_evt,
    output logic              ddcd_evt,
    input  logic              tx_ser,
    input  logic              sin,
    output logic              sout,
    output logic              rx_ser,
    input  logic              tx_ir,
    input  logic              ir_rx_pin,
    output logic              ir_tx_pin,
    output logic              rx_ir
);
    mc_ctrl_t        ctrl_q;
    logic [ST_W-1:0] pins_n;
    logic [ST_W-1:0] status_n;
    logic [ST_W-1:0] evt;

    // Gather external modem pins into the status vector layout.
    always_comb begin
        pins_n         = '1;
        pins_n[ST_CTS] = cts_pin_n;
        pins_n[ST_DSR] = dsr_pin_n;
        pins_n[ST_RI]  = ri_pin_n;
        pins_n[ST_DCD] = dcd_pin_n;
    end

    mc_ctrl_reg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET),
        .IR_EN(IR_EN), .AFC_EN(AFC_EN)
    ) i_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .wr_fields(bus_wdata[CTRL_W-1:0]), .bus_rdata(bus_rdata),
        .ctrl(ctrl_q)
    );

    mc_modem_mux i_mux (
        .ctrl(ctrl_q), .fifo_en(fifo_en), .rx_above_trig(rx_above_trig),
        .pins_n(pins_n), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
        .out2_n(out2_n), .status_n(status_n)
    );

    mc_serial_route i_route (
        .loop(ctrl_q.loop), .sire(ctrl_q.sire), .tx_ser(tx_ser), .sin(sin),
        .tx_ir(tx_ir), .ir_rx_pin(ir_rx_pin), .sout(sout), .rx_ser(rx_ser),
        .ir_tx_pin(ir_tx_pin), .rx_ir(rx_ir)
    );

    mc_delta_det i_delta (
        .clk(clk), .rst_n(rst_n), .status_n(status_n), .evt(evt)
    );

    // Break status and events out to named ports.
    always_comb begin
        cts_st_n = status_n[ST_CTS];
        dsr_st_n = status_n[ST_DSR];
        ri_st_n  = status_n[ST_RI];
        dcd_st_n = status_n[ST_DCD];
        dcts_evt = evt[ST_CTS];
        ddsr_evt = evt[ST_DSR];
        teri_evt = evt[ST_RI];
        ddcd_evt = evt[ST_DCD];
    end
endmodule

// File: rtl/mc_checker.sv
// Module: property checker bound to every uart_modem_ctl instance.
// Assumes the bus and pin ports of the top plus its stored control fields.
module mc_checker #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h10,
    parameter bit          IR_EN       = 1'b1,
    parameter bit          AFC_EN      = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [6:0]        ctrl,
    input logic              fifo_en,
    input logic              rx_above_trig,
    input logic              dtr_n,
    input logic              rts_n,
    input logic              out1_n,
    input logic              out2_n,
    input logic              cts_st_n,
    input logic              dcts_evt
);
    localparam logic [6:0] KEEP = {IR_EN, AFC_EN, 5'b11111};

    logic armed_q;

    // Arms the change check once a full post-reset sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFFSET)
        |=> ctrl == ($past(bus_wdata[6:0]) & KEEP));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:7] == '0);

    p_unbuilt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!IR_EN && !ctrl[6]) || IR_EN) && ((!AFC_EN && !ctrl[5]) || AFC_EN));

    p_rts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5] && fifo_en && rx_above_trig) |-> rts_n);

    p_loop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[4] |-> (dtr_n && rts_n && out1_n && out2_n));

    p_loop_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[4] |-> (cts_st_n == !ctrl[1]));

    p_cts_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cts_st_n != $past(cts_st_n)) |=> dcts_evt);

    p_other_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == CTRL_OFFSET) |=> $stable(ctrl));
endmodule

bind uart_modem_ctl mc_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET),
    .IR_EN(IR_EN), .AFC_EN(AFC_EN)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl_q),
    .fifo_en(fifo_en), .rx_above_trig(rx_above_trig), .dtr_n(dtr_n),
    .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .cts_st_n(cts_st_n),
    .dcts_evt(dcts_evt)
);

// File: tb/test_uart_modem_ctl.sv
// Bench: a stimulus table swept over all mode combinations against a pin
// model, then directed tests for reset, build options, addressing, events.
module test_uart_modem_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFF = 8'h10;
    // Each row: [11:8] {out2,out1,rts,dtr}, [7:4] pins {dcd,ri,dsr,cts},
    // [3:0] serial {tx_ser,sin,tx_ir,ir_rx_pin}.
    localparam logic [11:0] STIM [8] = '{
        12'h0F5, 12'hF0A, 12'h5A3, 12'hA5C, 12'h3C9, 12'hC36, 12'h96F, 12'h690
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = OFF;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_nb;
    logic fifo_en = 0, above = 0;
    logic cts_p = 1, dsr_p = 1, ri_p = 1, dcd_p = 1;
    logic tx_ser = 1, sin = 1, tx_ir = 0, ir_rx = 0;
    logic dtr_n, rts_n, out1_n, out2_n, cts_s, dsr_s, ri_s, dcd_s;
    logic e_cts, e_dsr, e_ri, e_dcd, sout, rx_ser, ir_pin, rx_ir;
    logic nb_dtr, nb_rts, nb_o1, nb_o2, nb_cs, nb_ds, nb_rs, nb_dc;
    logic nb_e0, nb_e1, nb_e2, nb_e3, nb_so, nb_rx, nb_ip, nb_ri;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl i_uart_modem_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .fifo_en(fifo_en),
        .rx_above_trig(above), .cts_pin_n(cts_p), .dsr_pin_n(dsr_p),
        .ri_pin_n(ri_p), .dcd_pin_n(dcd_p), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .cts_st_n(cts_s), .dsr_st_n(dsr_s),
        .ri_st_n(ri_s), .dcd_st_n(dcd_s), .dcts_evt(e_cts), .ddsr_evt(e_dsr),
        .teri_evt(e_ri), .ddcd_evt(e_dcd), .tx_ser(tx_ser), .sin(sin),
        .sout(sout), .rx_ser(rx_ser), .tx_ir(tx_ir), .ir_rx_pin(ir_rx),
        .ir_tx_pin(ir_pin), .rx_ir(rx_ir));

    uart_modem_ctl #(.IR_EN(1'b0), .AFC_EN(1'b0)) i_nobuild (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_nb), .fifo_en(fifo_en),
        .rx_above_trig(above), .cts_pin_n(cts_p), .dsr_pin_n(dsr_p),
        .ri_pin_n(ri_p), .dcd_pin_n(dcd_p), .dtr_n(nb_dtr), .rts_n(nb_rts),
        .out1_n(nb_o1), .out2_n(nb_o2), .cts_st_n(nb_cs), .dsr_st_n(nb_ds),
        .ri_st_n(nb_rs), .dcd_st_n(nb_dc), .dcts_evt(nb_e0), .ddsr_evt(nb_e1),
        .teri_evt(nb_e2), .ddcd_evt(nb_e3), .tx_ser(tx_ser), .sin(sin),
        .sout(nb_so), .rx_ser(nb_rx), .tx_ir(tx_ir), .ir_rx_pin(ir_rx),
        .ir_tx_pin(nb_ip), .rx_ir(nb_ri));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = OFF;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 modem outs", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
        chk("R1 serial", {sout, ir_pin}, {tx_ser, tx_ir});
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 after release", {rdata[6:0], e_cts, e_dsr, e_ri, e_dcd}, 11'h0);

        // Table sweep over every loop/afce/fifo_en/sire/fill combination.
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 32; c++) begin
                logic lp, af, fe, si, ab, dt, rt, o1, o2;
                logic rg, lbu, lbi;
                logic [3:0] exp_out, exp_st, exp_ser;
                lp = c[0]; af = c[1]; fe = c[2]; si = c[3]; ab = c[4];
                {o2, o1, rt, dt} = STIM[r][11:8];
                wr(OFF, {25'h0, si, af, lp, o2, o1, rt, dt});
                {dcd_p, ri_p, dsr_p, cts_p} = STIM[r][7:4];
                {tx_ser, sin, tx_ir, ir_rx} = STIM[r][3:0];
                fifo_en = fe; above = ab;
                #1;
                rg = rt && !(af && fe && ab);
                exp_out = {lp | ~dt, lp | ~rg, lp | ~o1, lp | ~o2};
                exp_st = lp ? {~rt, ~dt, ~o1, ~o2} : {cts_p, dsr_p, ri_p, dcd_p};
                lbu = lp && !si; lbi = lp && si;
                exp_ser = {lbu ? 1'b1 : tx_ser, lbu ? tx_ser : sin,
                           lbi ? 1'b0 : tx_ir, lbi ? ~tx_ir : ir_rx};
                chk(lp ? "R6 outs" : "R4/R5 outs", {dtr_n, rts_n, out1_n, out2_n}, exp_out);
                chk(lp ? "R7 status" : "R8 status", {cts_s, dsr_s, ri_s, dcd_s}, exp_st);
                chk(si ? "R10 serial" : "R9 serial", {sout, rx_ser, ir_pin, rx_ir}, exp_ser);
                chk("R2 readback", rdata, {25'h0, si, af, lp, o2, o1, rt, dt});
            end
        end

        // R5: gating releases when the FIFO drops below its trigger.
        wr(OFF, 32'h22); fifo_en = 1; above = 1; #1;
        chk("R5 held", rts_n, 1'b1);
        above = 0; #1;
        chk("R5 released", rts_n, 1'b0);

        // R3: unbuilt fields stay zero; afce has no gating effect there.
        wr(OFF, 32'hFFFF_FFFF); #1;
        chk("R3 readback", rdata_nb, 32'h1F);
        chk("R2 reserved zero", rdata, 32'h7F);
        wr(OFF, 32'h22); fifo_en = 1; above = 1; #1;
        chk("R3 no gating", nb_rts, 1'b0);

        // R12: other address ignored, reads zero.
        wr(OFF, 32'h0B);
        wr(8'h14, 32'h7F);
        #1;
        chk("R12 unchanged", rdata, 32'h0B);
        bus_addr = 8'h14; #1;
        chk("R12 other read", rdata, 32'h0);
        bus_addr = OFF;

        // R11: pin-driven event, one cycle only.
        wr(OFF, 32'h0);
        {cts_p, dsr_p, ri_p, dcd_p} = 4'hF;
        repeat (2) @(negedge clk);
        cts_p = 0;
        @(negedge clk); #1;
        chk("R11 pin event", {e_cts, e_dsr, e_ri, e_dcd}, 4'b1000);
        @(negedge clk); #1;
        chk("R11 one cycle", {e_cts, e_dsr, e_ri, e_dcd}, 4'b0000);
        ri_p = 0;
        @(negedge clk); #1;
        chk("R11 ri falling silent", e_ri, 1'b0);
        ri_p = 1;
        @(negedge clk); #1;
        chk("R11 ri trailing", e_ri, 1'b1);

        // R11: write-driven events in loopback.
        wr(OFF, 32'h10);
        repeat (2) @(negedge clk);
        wr(OFF, 32'h1A); #1;
        chk("R11 write edge", {e_cts, e_dcd}, 2'b00);
        @(negedge clk); #1;
        chk("R11 loop event", {e_cts, e_dsr, e_ri, e_dcd}, 4'b1001);
        wr(OFF, 32'h14);
        @(negedge clk); #1;
        chk("R11 ri asserted silent", e_ri, 1'b0);
        wr(OFF, 32'h10);
        @(negedge clk); #1;
        chk("R11 loop ri trailing", e_ri, 1'b1);

        // R7: external pins ignored in loopback.
        cts_p = 0; dsr_p = 0; ri_p = 0; dcd_p = 0; #1;
        chk("R7 pins ignored", {cts_s, dsr_s, ri_s, dcd_s}, 4'hF);

        // R1: reset clears a populated register.
        wr(OFF, 32'h7F);
        @(negedge clk); rst_n = 0;
        @(negedge clk); #1;
        chk("R1 re-reset", {rdata[6:0], dtr_n, rts_n, out1_n, out2_n}, {7'h0, 4'hF});
        finish_run();
    end
endmodule